// File: doc/BRIEF.md
# Resynchronizing UART Baud Generator

This block derives the timing strobes a UART receiver and transmitter need from a single system clock. A fixed divide-by-four turns the system clock into a reference rate. A programmable divider counts N reference periods, with N anywhere from 1 to 1024, and emits a one-cycle oversampling tick at sixteen times the bit rate. A 16-step phase counter turns those ticks into a bit-rate tick and a strobe in the middle of each bit.

The phase counter realigns to the incoming data. The raw receive line passes through a two-flop synchronizer. Every level change seen there, rising or falling, clears the phase counter. The mid-bit strobe therefore stays centred on every data bit, not only on the start bit. When the enable input is low, every counter is cleared and no strobe is produced.

Top module: `uart_baud_resync`

## Requirements
- R1: The reference rate is one pulse every 4 system clocks. With `div_m1 = 0`, `os_tick` pulses exactly every 4 cycles.
- R2: `div_m1` holds N-1, for N from 1 to 1024. While enabled with a constant divisor, consecutive `os_tick` pulses are exactly 4*N clock cycles apart.
- R3: `bit_tick` pulses in the same cycle as the 16th `os_tick` counted since the phase counter was last cleared, and every 16 ticks after that.
- R4: A level change on `rx_line` that is held stable clears the phase counter at the third rising clock edge after the change. An `os_tick` in the cycle before that edge is not counted and produces no `sample_strobe` or `bit_tick`.
- R5: `sample_strobe` pulses in the same cycle as the 8th `os_tick` counted since the phase counter was last cleared. If transitions arrive fewer than 8 ticks apart, no strobe occurs.
- R6: While `enable` is low, `os_tick`, `bit_tick` and `sample_strobe` stay 0 and all counters are cleared. After `enable` rises, phase counting restarts from zero.
- R7: During and immediately after reset, all three outputs are 0.
- R8: Rising and falling transitions of `rx_line` both realign the phase counter.
- R9: `sample_strobe` and `bit_tick` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; clears all counters when low |
| div_m1 | input | 10 | Programmable divisor minus one (N-1) |
| rx_line | input | 1 | Raw, asynchronous receive line |
| os_tick | output | 1 | One-cycle pulse at 16x the bit rate |
| bit_tick | output | 1 | One-cycle pulse once per bit period |
| sample_strobe | output | 1 | One-cycle pulse at the middle of each bit |

## Verification
`os_tick` is registered. Its spacing of 4*N cycles is checked by measuring the distance between consecutive pulses against intervals queued by the driver. A change on `rx_line` takes effect at the third rising edge after it. The monitor models this with a two-deep history of the line it samples at each falling edge, and treats the cycle in which that history differs as the cycle where any tick is discarded. `sample_strobe` and `bit_tick` are combinational from the phase state and the registered tick. They are therefore expected in the same falling-edge sample as the 8th and 16th counted tick, and the monitor compares them there every cycle.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
    localparam int unsigned BAUD_PRE_DIV_DEF = 4;
    localparam int unsigned BAUD_DIV_W_DEF   = 10;
    localparam int unsigned BAUD_OVS_DEF     = 16;

    function automatic int unsigned cnt_width(input int unsigned modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
    import uart_baud_pkg::*;
#(
    parameter int unsigned PRE_DIV = BAUD_PRE_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ref_tick
);
    localparam int unsigned CW = cnt_width(PRE_DIV);
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        ref_tick = 1'b0;
        if (!en) begin
            state_d.cnt = '0;
        end else if (state_q.cnt == LAST) begin
            ref_tick    = 1'b1;
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    generate
        if (PRE_DIV > 1) begin : g_spacing_chk
            // R1: reference pulses are never back to back
            a_r1_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                ref_tick |=> !ref_tick);
        end
    endgenerate
endmodule

// File: rtl/baud_os_divider.sv
module baud_os_divider
    import uart_baud_pkg::*;
#(
    parameter int unsigned DIV_W = BAUD_DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div_m1,
    output logic             os_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.tick = 1'b0;
        if (!en) begin
            state_d.cnt = '0;
        end else if (ref_tick) begin
            if (state_q.cnt == div_m1) begin
                state_d.cnt  = '0;
                state_d.tick = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign os_tick = state_q.tick;

    // R2: every oversampling tick follows a reference pulse
    a_r2_tick_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> $past(ref_tick));
endmodule

// File: rtl/rx_resync.sv
module rx_resync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx_raw,
    output logic line_edge
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.s1   = rx_raw;
        state_d.s2   = state_q.s1;
        state_d.prev = state_q.s2;
        line_edge    = en && (state_q.s2 != state_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '1;
        else        state_q <= state_d;
    end

    // R8: an edge is reported only when the synchronized line has just moved
    a_r8_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |-> (state_q.s2 != $past(state_q.s2)));
endmodule

// File: rtl/bit_phase.sv
module bit_phase
    import uart_baud_pkg::*;
#(
    parameter int unsigned OVS       = BAUD_OVS_DEF,
    parameter int unsigned SAMPLE_AT = OVS / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic os_tick,
    input  logic line_edge,
    output logic sample_strobe,
    output logic bit_tick
);
    localparam int unsigned PW = cnt_width(OVS);
    localparam logic [PW-1:0] PH_LAST   = PW'(OVS - 1);
    localparam logic [PW-1:0] PH_SAMPLE = PW'(SAMPLE_AT - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
    } phase_state_t;

    phase_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        sample_strobe = 1'b0;
        bit_tick      = 1'b0;
        if (!en || line_edge) begin
            state_d.ph = '0;
        end else if (os_tick) begin
            sample_strobe = (state_q.ph == PH_SAMPLE);
            bit_tick      = (state_q.ph == PH_LAST);
            state_d.ph    = (state_q.ph == PH_LAST) ? '0 : state_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R4: a line transition restarts the phase count
    a_r4_realign: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> (state_q.ph == '0));
    // R5: the mid-bit strobe rides on an oversampling tick
    a_r5_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> os_tick);
    // R3: the bit tick rides on an oversampling tick
    a_r3_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    // R9: the two strobes are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_strobe && bit_tick));
    // R6: disabling clears the phase
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q.ph == '0));
endmodule

// File: rtl/uart_baud_resync.sv
module uart_baud_resync
    import uart_baud_pkg::*;
#(
    parameter int unsigned PRE_DIV = BAUD_PRE_DIV_DEF,
    parameter int unsigned DIV_W   = BAUD_DIV_W_DEF,
    parameter int unsigned OVS     = BAUD_OVS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             rx_line,
    output logic             os_tick,
    output logic             bit_tick,
    output logic             sample_strobe
);
    logic ref_tick;
    logic os_raw;
    logic line_edge;

    baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .ref_tick (ref_tick)
    );

    baud_os_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .ref_tick (ref_tick),
        .div_m1   (div_m1),
        .os_tick  (os_raw)
    );

    assign os_tick = os_raw && enable;

    rx_resync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .rx_raw    (rx_line),
        .line_edge (line_edge)
    );

    bit_phase #(.OVS(OVS), .SAMPLE_AT(OVS / 2)) u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (enable),
        .os_tick       (os_tick),
        .line_edge     (line_edge),
        .sample_strobe (sample_strobe),
        .bit_tick      (bit_tick)
    );

    // R7: outputs are quiet in the first cycle after reset
    a_r7_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !os_tick && !bit_tick && !sample_strobe);
endmodule

// File: tb/uart_baud_resync_test.sv
module uart_baud_resync_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [9:0] div_m1 = '0;
    logic       rx_line = 1'b1;
    logic       os_tick, bit_tick, sample_strobe;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    longint last_os = -1;
    int     cnt = 0;
    bit     h1 = 1'b1, h2 = 1'b1;
    bit     done = 1'b0;
    bit     edge_obs, exp_s, exp_b;
    int     exp_q[$];

    always #4 clk = ~clk;

    uart_baud_resync uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_m1(div_m1),
        .rx_line(rx_line), .os_tick(os_tick), .bit_tick(bit_tick),
        .sample_strobe(sample_strobe)
    );

    // monitor: model of phase count and scoreboard for tick spacing
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            checks++;
            if (os_tick || bit_tick || sample_strobe) begin
                errors++;
                $display("FAIL R7 outputs in reset: %b%b%b expected 000", os_tick, bit_tick, sample_strobe);
            end
        end else if (!enable) begin
            checks++;
            if (os_tick || bit_tick || sample_strobe) begin
                errors++;
                $display("FAIL R6 outputs while disabled: %b%b%b expected 000", os_tick, bit_tick, sample_strobe);
            end
            cnt = 0;
            last_os = -1;
        end else begin
            edge_obs = (h1 != h2);
            exp_s = os_tick && (cnt == 7) && !edge_obs;
            exp_b = os_tick && (cnt == 15) && !edge_obs;
            if (sample_strobe || exp_s) begin
                checks++;
                if (sample_strobe != exp_s) begin
                    errors++;
                    $display("FAIL R5 R4 R8 sample_strobe=%b expected %b (count %0d)", sample_strobe, exp_s, cnt);
                end
            end
            if (bit_tick || exp_b) begin
                checks++;
                if (bit_tick != exp_b) begin
                    errors++;
                    $display("FAIL R3 bit_tick=%b expected %b (count %0d)", bit_tick, exp_b, cnt);
                end
            end
            if (sample_strobe && bit_tick) begin
                checks++;
                errors++;
                $display("FAIL R9 both strobes=11 expected at most one");
            end
            if (edge_obs) cnt = 0;
            else if (os_tick) cnt = (cnt + 1) % 16;
            if (os_tick) begin
                if (last_os >= 0 && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    checks++;
                    if (cyc - last_os != longint'(e)) begin
                        errors++;
                        $display("FAIL R1 R2 tick gap=%0d expected %0d", cyc - last_os, e);
                    end
                end
                last_os = cyc;
            end
        end
        h2 = h1;
        h1 = rx_line;
    end

    task automatic run_div(input int n, input int k, input int gap);
        @(negedge clk); #1 enable = 1'b0;
        repeat (3) @(negedge clk);
        #1 div_m1 = 10'(n - 1);
        for (int i = 0; i < k; i++) exp_q.push_back(4 * n);
        @(negedge clk); #1 enable = 1'b1;
        begin
            int t = 0;
            while (exp_q.size() > 0) begin
                @(negedge clk);
                t++;
                if (gap > 0 && (t % gap) == 0) #1 rx_line = ~rx_line;
            end
        end
        repeat (8) @(negedge clk);
        #1 enable = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired, queue left %0d expected 0", exp_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);   // R7 reset checks
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);   // R6 disabled checks
        run_div(1, 40, 0);           // R1 R3 free running
        run_div(1, 40, 37);          // R4 R5 R8 realign on both polarities
        run_div(3, 20, 101);
        run_div(2, 30, 5);           // R5 edges too close: no strobe
        run_div(7, 10, 300);
        run_div(1024, 2, 0);         // R2 largest divisor
        run_div(16, 6, 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule